// File: doc/BRIEF.md
# Display-Gated Upper Memory Router

This block sits between an 8-bit processor bus and the upper half (0x8000 to 0xFFFF) of a 16-bit address map on a handheld-console-style system. It decodes each access by address and steers it to one of four on-chip byte arrays (video memory, work memory, sprite attribute memory and a small high page), to an I/O register port, or to an external RAM port. Addresses in the lower half of the space read as zero and take no writes.

Access to video and sprite memory depends on a 2-bit display-mode input that comes from the pixel pipeline. The permitted mode sets differ between the two arrays. Blocked reads return a fixed byte and blocked writes are dropped, so the processor never stalls. Reads return one cycle after the strobe, together with a registered valid flag. A write takes effect on the edge where its strobe is high.

Top module: `mem_route_top`

## Requirements
- R1: 0x8000-0x9FFF reaches video memory and 0xC000-0xFDFF reaches work memory. Each array is indexed by the low VID_AW and WRK_AW address bits (default 11), so 0xE000-0xFDFF reaches the same cells as 0xC000-0xDDFF.
- R2: The display mode is encoded 0 = horizontal blank, 1 = vertical blank, 2 = sprite search, 3 = pixel transfer. A video memory read issued in mode 3 returns 0xFF. In modes 0-2 it returns the stored byte.
- R3: A video memory write changes the array only in modes 0, 1 and 2. In mode 3 it is dropped.
- R4: Sprite attribute memory (0xFE00-0xFE9F, 160 bytes, indexed by addr-0xFE00) is read and written only in modes 0 and 1. A read in modes 2 or 3 returns 0x00, and a write in those modes is dropped.
- R5: Reads of 0xFEA0-0xFEFF return 0x00. Writes to that range change no array and raise no port strobe.
- R6: 0xFF00-0xFF7F and 0xFFFF drive io_rd or io_wr, with io_addr = addr[7:0] and io_wdata = wdata. A read there returns the io_rdata value present in the strobe cycle. No other address raises io_rd or io_wr.
- R7: 0xFF80-0xFFFE reaches a high page array indexed by addr[6:0].
- R8: Reads of 0xA000-0xBFFF return 0x00. A write there raises xr_we, with xr_addr = addr[12:0] and xr_wdata = wdata, only while xram_present is 1.
- R9: Reads below 0x8000 return 0x00. Writes below 0x8000 change no array and raise no port strobe.
- R10: rvalid and rdata appear in the cycle after rd_en. When rd_en and wr_en are high together at the same address, the read returns the byte held before that write.
- R11: Out of reset, rvalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Bus write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| disp_mode | input | 2 | Display mode from the pixel pipeline |
| xram_present | input | 1 | External RAM fitted |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| io_addr | output | 8 | I/O register offset |
| io_wdata | output | 8 | I/O write data |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_rdata | input | 8 | I/O read data, sampled in the strobe cycle |
| xr_addr | output | 13 | External RAM address |
| xr_wdata | output | 8 | External RAM write data |
| xr_we | output | 1 | External RAM write strobe |

## Verification
A read and a write can land in the same cycle. When both hit the same cell, the read must return the byte from before the write. The bench raises both strobes together on a work memory cell, then expects the old byte in the next cycle and the new byte on a later read. The mode-permission check and the access also share a cycle. For every pair of write mode and read mode, the bench first seeds video and sprite cells, then writes with the mode held for exactly that cycle and reads in another mode. A reference model applies the permission rules and judges each returned byte.

// File: rtl/mem_route_pkg.sv
package mem_route_pkg;

  typedef enum logic [1:0] {
    DM_HBLANK      = 2'd0,
    DM_VBLANK      = 2'd1,
    DM_SPRITE_SCAN = 2'd2,
    DM_XFER        = 2'd3
  } disp_mode_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_VID,
    RG_XRAM,
    RG_WRK,
    RG_OAM,
    RG_VOID,
    RG_IO,
    RG_HI
  } region_e;

  localparam int OAM_BYTES = 160;
  localparam int HI_BYTES  = 128;

  function automatic region_e decode_region(input logic [15:0] a);
    region_e r;
    if (!a[15])                        r = RG_NONE;
    else if (a[14:13] == 2'b00)        r = RG_VID;
    else if (a[14:13] == 2'b01)        r = RG_XRAM;
    else if (a[15:9] != 7'b1111_111)   r = RG_WRK;
    else if (!a[8])                    r = (a[7:0] < 8'hA0) ? RG_OAM : RG_VOID;
    else if (!a[7] || (&a[6:0]))       r = RG_IO;
    else                               r = RG_HI;
    return r;
  endfunction

endpackage

// File: rtl/mr_rst_sync.sv
module mr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/mr_decode.sv
module mr_decode
  import mem_route_pkg::*;
(
  input  logic [15:0] addr,
  input  logic [1:0]  mode,
  output region_e     region,
  output logic        rd_open,
  output logic        wr_open
);
  disp_mode_e m;
  logic vid_open;
  logic oam_open;

  always_comb begin
    m        = disp_mode_e'(mode);
    region   = decode_region(addr);
    vid_open = (m != DM_XFER);
    oam_open = (m == DM_HBLANK) || (m == DM_VBLANK);
    case (region)
      RG_VID: begin
        rd_open = vid_open;
        wr_open = vid_open;
      end
      RG_OAM: begin
        rd_open = oam_open;
        wr_open = oam_open;
      end
      RG_VOID, RG_NONE: begin
        rd_open = 1'b0;
        wr_open = 1'b0;
      end
      default: begin
        rd_open = 1'b1;
        wr_open = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/mr_sram.sv
module mr_sram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          re,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (re) q <= mem[a];
    if (we) mem[a] <= d;
  end
endmodule

// File: rtl/mem_route_top.sv
module mem_route_top
  import mem_route_pkg::*;
#(
  parameter int VID_AW = 11,
  parameter int WRK_AW = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [1:0]  disp_mode,
  input  logic        xram_present,
  output logic [7:0]  rdata,
  output logic        rvalid,
  output logic [7:0]  io_addr,
  output logic [7:0]  io_wdata,
  output logic        io_rd,
  output logic        io_wr,
  input  logic [7:0]  io_rdata,
  output logic [12:0] xr_addr,
  output logic [7:0]  xr_wdata,
  output logic        xr_we
);
  localparam int VID_DEPTH = 1 << VID_AW;
  localparam int WRK_DEPTH = 1 << WRK_AW;
  localparam int OAM_AW    = $clog2(OAM_BYTES);
  localparam int HI_AW     = $clog2(HI_BYTES);

  logic    rst_n_s;
  region_e region;
  logic    rd_open, wr_open;

  mr_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  mr_decode u_dec (
    .addr(addr), .mode(disp_mode),
    .region(region), .rd_open(rd_open), .wr_open(wr_open)
  );

  // array strobes
  logic vid_re, vid_we, wrk_re, wrk_we, oam_re, oam_we, hi_re, hi_we;
  logic [7:0] vid_q, wrk_q, oam_q, hi_q;

  always_comb begin
    vid_re = rd_en && (region == RG_VID);
    vid_we = wr_en && (region == RG_VID) && wr_open;
    wrk_re = rd_en && (region == RG_WRK);
    wrk_we = wr_en && (region == RG_WRK);
    oam_re = rd_en && (region == RG_OAM);
    oam_we = wr_en && (region == RG_OAM) && wr_open;
    hi_re  = rd_en && (region == RG_HI);
    hi_we  = wr_en && (region == RG_HI);
  end

  mr_sram #(.DEPTH(VID_DEPTH)) u_vid (
    .clk(clk), .re(vid_re), .we(vid_we),
    .a(addr[VID_AW-1:0]), .d(wdata), .q(vid_q)
  );
  mr_sram #(.DEPTH(WRK_DEPTH)) u_wrk (
    .clk(clk), .re(wrk_re), .we(wrk_we),
    .a(addr[WRK_AW-1:0]), .d(wdata), .q(wrk_q)
  );
  mr_sram #(.DEPTH(OAM_BYTES)) u_oam (
    .clk(clk), .re(oam_re), .we(oam_we),
    .a(addr[OAM_AW-1:0]), .d(wdata), .q(oam_q)
  );
  mr_sram #(.DEPTH(HI_BYTES)) u_hi (
    .clk(clk), .re(hi_re), .we(hi_we),
    .a(addr[HI_AW-1:0]), .d(wdata), .q(hi_q)
  );

  // forwarded ports
  assign io_addr  = addr[7:0];
  assign io_wdata = wdata;
  assign io_rd    = rd_en && (region == RG_IO);
  assign io_wr    = wr_en && (region == RG_IO);
  assign xr_addr  = addr[12:0];
  assign xr_wdata = wdata;
  assign xr_we    = wr_en && (region == RG_XRAM) && xram_present;

  // read return: next-state then register
  region_e rsel_d, rsel_q;
  logic    ropen_d, ropen_q;
  logic [7:0] io_d, io_q;
  logic    rvalid_d, rvalid_q;
  logic    cap_en;

  always_comb begin
    cap_en   = rd_en;
    rsel_d   = region;
    ropen_d  = rd_open;
    io_d     = io_rdata;
    rvalid_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsel_q   <= RG_NONE;
      ropen_q  <= 1'b0;
      io_q     <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      if (cap_en) begin
        rsel_q  <= rsel_d;
        ropen_q <= ropen_d;
        io_q    <= io_d;
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RG_VID:  rdata = ropen_q ? vid_q : 8'hFF;
      RG_WRK:  rdata = wrk_q;
      RG_OAM:  rdata = ropen_q ? oam_q : 8'h00;
      RG_HI:   rdata = hi_q;
      RG_IO:   rdata = io_q;
      default: rdata = 8'h00;
    endcase
  end

  assign rvalid = rvalid_q;

  // R2: video read in pixel transfer yields 0xFF
  a_r2_vid_xfer_ff: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && addr[15:13] == 3'b100 && disp_mode == 2'd3) |=> (rdata == 8'hFF));

  // R4: sprite read outside the blanks yields 0x00
  a_r4_oam_closed_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && addr >= 16'hFE00 && addr < 16'hFEA0 && disp_mode[1]) |=> (rdata == 8'h00));

  // R5: unused sprite page tail reads zero
  a_r5_void_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && addr[15:8] == 8'hFE && addr[7:0] >= 8'hA0) |=> (rdata == 8'h00));

  // R6: I/O strobes only inside the register window
  a_r6_io_range: assert property (@(posedge clk) disable iff (!rst_n_s)
    (io_wr || io_rd) |-> (addr[15:8] == 8'hFF && (!addr[7] || addr[7:0] == 8'hFF)));

  // R8: external write only with RAM fitted
  a_r8_xr_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    xr_we |-> (xram_present && wr_en && addr[15:13] == 3'b101));

  // R9: lower half reads zero
  a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && !addr[15]) |=> (rdata == 8'h00));

  // R10: valid follows the read strobe by one cycle
  a_r10_rvalid_follow: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_en |=> rvalid);
  a_r10_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |=> !rvalid);
endmodule

// File: tb/sim_mem_route_top.sv
module sim_mem_route_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rd_en, wr_en;
  logic [1:0]  disp_mode;
  logic        xram_present;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [7:0]  io_addr, io_wdata;
  logic        io_rd, io_wr;
  logic [7:0]  io_rdata;
  logic [12:0] xr_addr;
  logic [7:0]  xr_wdata;
  logic        xr_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign io_rdata = io_addr ^ 8'hA5;

  mem_route_top u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .disp_mode(disp_mode),
    .xram_present(xram_present), .rdata(rdata), .rvalid(rvalid),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata), .xr_addr(xr_addr), .xr_wdata(xr_wdata), .xr_we(xr_we)
  );

  // reference model
  logic [7:0] vid_m [2048];
  logic [7:0] wrk_m [2048];
  logic [7:0] oam_m [160];
  logic [7:0] hi_m  [128];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  function automatic string tag_of(input logic [15:0] a);
    if (a < 16'h8000) return "R9";
    if (a < 16'hA000) return "R2";
    if (a < 16'hC000) return "R8";
    if (a < 16'hFE00) return "R1";
    if (a < 16'hFEA0) return "R4";
    if (a < 16'hFF00) return "R5";
    if (a < 16'hFF80 || a == 16'hFFFF) return "R6";
    return "R7";
  endfunction

  function automatic logic [7:0] model_read(input logic [15:0] a, input logic [1:0] m);
    if (a < 16'h8000) return 8'h00;
    if (a < 16'hA000) return (m == 2'd3) ? 8'hFF : vid_m[a[10:0]];
    if (a < 16'hC000) return 8'h00;
    if (a < 16'hFE00) return wrk_m[a[10:0]];
    if (a < 16'hFEA0) return (m < 2'd2) ? oam_m[a[7:0]] : 8'h00;
    if (a < 16'hFF00) return 8'h00;
    if (a < 16'hFF80 || a == 16'hFFFF) return a[7:0] ^ 8'hA5;
    return hi_m[a[6:0]];
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [1:0] m, input logic [7:0] d);
    if (a >= 16'h8000 && a < 16'hA000) begin
      if (m != 2'd3) vid_m[a[10:0]] = d;
    end else if (a >= 16'hC000 && a < 16'hFE00) begin
      wrk_m[a[10:0]] = d;
    end else if (a >= 16'hFE00 && a < 16'hFEA0) begin
      if (m < 2'd2) oam_m[a[7:0]] = d;
    end else if (a >= 16'hFF80 && a < 16'hFFFF) begin
      hi_m[a[6:0]] = d;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one bus cycle, pushes expected read data, checks port strobes
  task automatic access(input logic [15:0] a, input logic [1:0] m, input bit rd,
                        input bit wr, input logic [7:0] d, input bit pres);
    bit io_hit, xr_hit;
    @(negedge clk);
    addr = a; disp_mode = m; rd_en = rd; wr_en = wr; wdata = d; xram_present = pres;
    io_hit = (a >= 16'hFF00 && a < 16'hFF80) || a == 16'hFFFF;
    xr_hit = (a >= 16'hA000 && a < 16'hC000);
    if (rd) begin
      exp_q.push_back(model_read(a, m));
      tag_q.push_back(rd && wr ? "R10" : tag_of(a));
    end
    if (wr) model_write(a, m, d);
    #1;
    if (wr) begin
      chk(io_hit ? "R6" : "R9", {31'd0, io_wr}, {31'd0, io_hit});
      chk("R8", {31'd0, xr_we}, {31'd0, xr_hit && pres});
      if (io_hit) chk("R6", {16'd0, io_addr, io_wdata}, {16'd0, a[7:0], d});
      if (xr_hit && pres) chk("R8", {11'd0, xr_addr, xr_wdata}, {11'd0, a[12:0], d});
    end
    if (rd) chk("R6", {31'd0, io_rd}, {31'd0, io_hit});
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] m, input logic [7:0] d);
    access(a, m, 1'b0, 1'b1, d, 1'b0);
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] m);
    access(a, m, 1'b1, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
    end
  endtask

  // monitor: pops expected items as read data returns
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual=rvalid expected=no read pending");
      end else begin
        chk(tag_q.pop_front(), {24'd0, rdata}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; rd_en = 0; wr_en = 0;
    disp_mode = 2'd0; xram_present = 0;
    for (int i = 0; i < 2048; i++) begin vid_m[i] = 0; wrk_m[i] = 0; end
    for (int i = 0; i < 160; i++) oam_m[i] = 0;
    for (int i = 0; i < 128; i++) hi_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", {31'd0, rvalid}, 32'd0);

    // R1/R2/R3 video memory boundaries and gating
    wr(16'h8000, 2'd0, 8'h11);
    wr(16'h9FFF, 2'd2, 8'h22);
    rd(16'h8000, 2'd1);
    rd(16'h9FFF, 2'd0);
    rd(16'h8000, 2'd3);
    wr(16'h8010, 2'd1, 8'h33);
    wr(16'h8010, 2'd3, 8'h99);
    rd(16'h8010, 2'd0);

    // R1 work memory and its mirror
    wr(16'hC000, 2'd3, 8'h44);
    rd(16'hE000, 2'd3);
    wr(16'hE123, 2'd0, 8'h55);
    rd(16'hC123, 2'd2);
    wr(16'hFDFF, 2'd1, 8'h56);
    rd(16'hDDFF, 2'd0);
    rd(16'hFDFF, 2'd3);

    // R4 sprite memory
    wr(16'hFE00, 2'd0, 8'h66);
    wr(16'hFE9F, 2'd1, 8'h77);
    rd(16'hFE00, 2'd1);
    rd(16'hFE9F, 2'd0);
    wr(16'hFE00, 2'd2, 8'h88);
    wr(16'hFE00, 2'd3, 8'h89);
    rd(16'hFE00, 2'd2);
    rd(16'hFE00, 2'd3);
    rd(16'hFE00, 2'd0);

    // R5 unused tail
    wr(16'hFEA0, 2'd0, 8'hAB);
    wr(16'hFEFF, 2'd0, 8'hAC);
    rd(16'hFEA0, 2'd0);
    rd(16'hFEFF, 2'd1);
    rd(16'hFE9F, 2'd0);
    rd(16'hFE00, 2'd0);

    // R6 I/O window edges
    wr(16'hFF00, 2'd0, 8'h01);
    wr(16'hFF7F, 2'd3, 8'h02);
    wr(16'hFFFF, 2'd2, 8'h03);
    rd(16'hFF00, 2'd0);
    rd(16'hFF7F, 2'd3);
    rd(16'hFFFF, 2'd1);

    // R7 high page
    wr(16'hFF80, 2'd3, 8'hC1);
    wr(16'hFFFE, 2'd0, 8'hC2);
    rd(16'hFF80, 2'd2);
    rd(16'hFFFE, 2'd3);

    // R8 external RAM port
    access(16'hA000, 2'd0, 1'b0, 1'b1, 8'hD1, 1'b1);
    access(16'hBFFF, 2'd3, 1'b0, 1'b1, 8'hD2, 1'b1);
    access(16'hA5A5, 2'd0, 1'b0, 1'b1, 8'hD3, 1'b0);
    access(16'hA000, 2'd0, 1'b1, 1'b0, 8'h00, 1'b1);

    // R9 lower half: reads zero, writes reach nothing
    wr(16'h7FFF, 2'd0, 8'hE1);
    wr(16'h4000, 2'd0, 8'hE2);
    wr(16'h0010, 2'd0, 8'hE3);
    rd(16'h7FFF, 2'd0);
    rd(16'h0000, 2'd1);
    rd(16'hC000, 2'd0);
    rd(16'h8000, 2'd0);
    rd(16'h8010, 2'd0);

    // R10 read and write in one cycle on one cell
    wr(16'hC200, 2'd0, 8'h12);
    access(16'hC200, 2'd0, 1'b1, 1'b1, 8'h34, 1'b0);
    rd(16'hC200, 2'd0);
    idle(1);
    @(negedge clk);
    chk("R10", {31'd0, rvalid}, 32'd0);

    // R2 R3 R4 every write-mode / read-mode pair
    for (int wm = 0; wm < 4; wm++) begin
      for (int rm = 0; rm < 4; rm++) begin
        logic [7:0] v;
        v = 8'(wm * 16 + rm);
        wr(16'h9000, 2'd0, 8'hF0 ^ v);
        wr(16'hFE50, 2'd0, 8'h0F ^ v);
        wr(16'h9000, 2'(wm), v);
        wr(16'hFE50, 2'(wm), ~v);
        rd(16'h9000, 2'(rm));
        rd(16'hFE50, 2'(rm));
        rd(16'h9000, 2'd1);
        rd(16'hFE50, 2'd1);
      end
    end

    idle(4);
    chk("R10", exp_q.size(), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule